// File: doc/BRIEF.md
# System-bus to peripheral-bus bridge with posted writes

This bridge joins a pipelined high-performance system bus (AHB-style) to a low-power peripheral bus (APB-style). On the system side it is a slave. On the peripheral side it is the only master. When the bridge accepts an address phase, it saves the address and the direction. Write data is saved from the following data phase. Each saved transfer is kept in a single holding register, and a three-phase sequencer (idle, setup, enable) drains that register onto the peripheral bus.

Writes are posted. The system-side master sees its write complete as soon as the holding register can take the data, so it moves on while the slow peripheral cycle is still running. Reads cannot be posted. A read keeps the system-side ready low until the peripheral's read data has been sampled. One of the peripheral selects is chosen by decoding a field of the held address. After a transfer, the peripheral address and direction keep their last values, so the peripheral-side wires do not toggle while the bus is quiet.

Top module: `sysbus_periph_bridge`

## Requirements
- R1: After a synchronous active-low reset, `hreadyout` is 1, `psel` is all zero, `penable` is 0 and `hrdata` is 0.
- R2: A transfer is accepted only in a cycle with `hsel`=1, `hready`=1 and `htrans` equal to 2 (NONSEQ) or 3 (SEQ). Cycles with `htrans` 0 (IDLE) or 1 (BUSY), or with `hsel`=0, start no peripheral access and leave `paddr` unchanged.
- R3: A write whose data phase finds the holding register free completes in that cycle with `hreadyout`=1. The setup phase follows in the next cycle.
- R4: The setup phase lasts exactly one cycle, with a select asserted and `penable`=0. The next cycle is always an enable phase with `penable`=1. `penable` is never high without a select.
- R5: `paddr`, `pwrite`, `pwdata` and `psel` have the same values in the enable phase as in the setup phase.
- R6: At most one select bit is set at a time. During a transfer, the set bit is index `paddr[SEL_LSB +: SEL_BITS]` (bits 13:12 with the default parameters).
- R7: A read holds `hreadyout` low through its data phase, the setup phase and the enable phase. In the cycle after the enable phase, `hreadyout` is 1 and `hrdata` equals the `prdata` value presented during the enable phase.
- R8: If a transfer's data phase arrives while a posted write is still in progress on the peripheral side, `hreadyout` stays low until that write's enable cycle. In that enable cycle the new transfer is taken, and the next cycle is its setup phase, with no idle cycle in between.
- R9: Between transfers, `psel`=0 and `penable`=0, while `paddr` and `pwrite` keep the values of the last transfer.
- R10: The write data driven on `pwdata` is the `hwdata` value from the write's data phase, not the value present during its address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock shared by both buses |
| hresetn | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Bridge selected on the system bus |
| haddr | input | ADDR_W | System-bus address |
| htrans | input | 2 | Transfer type (0 idle, 1 busy, 2 nonseq, 3 seq) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | System-bus ready seen by all slaves |
| hreadyout | output | 1 | Bridge ready; low stalls the current data phase |
| hrdata | output | DATA_W | Read data returned to the system bus |
| paddr | output | ADDR_W | Peripheral address, held between transfers |
| pwrite | output | 1 | Peripheral direction, held between transfers |
| pwdata | output | DATA_W | Peripheral write data |
| psel | output | 2**SEL_BITS | One-hot peripheral select |
| penable | output | 1 | Enable-phase strobe |
| prdata | input | DATA_W | Read data from the selected peripheral |

## Verification
The bench uses the default configuration: 16-bit addresses, 32-bit data and a 2-bit select field at bit 12. With these values, every one of the four selects can be reached by a sweep over the address. For each select, the sweep runs writes and reads at several offsets and checks each cycle of the setup and enable phases. The peripheral's read data is a function of the address computed in the bench. The same small configuration makes it practical to script the busy-buffer cases exactly: a write followed at once by a write, and a write followed at once by a read. The bench checks, cycle by cycle, when `hreadyout` is low and that the enable phase passes directly to the next setup phase.

// File: rtl/bridge_pkg.sv
// Shared types for the system-bus to peripheral-bus bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package bridge_pkg;

    // Peripheral-side sequencer phase.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ENABLE = 2'd2
    } apb_phase_e;

    // System-bus transfer types that carry a transfer.
    localparam logic [1:0] HT_NONSEQ = 2'd2;
    localparam logic [1:0] HT_SEQ    = 2'd3;

endpackage

// File: rtl/bridge_sel_decode.sv
// Turns the select field of the held address into a one-hot peripheral select.
// Assumes: the caller passes only the select field; gating by phase is done elsewhere.
module bridge_sel_decode #(
    parameter int SEL_BITS = 2,
    localparam int NUM_SEL = 1 << SEL_BITS
) (
    input  logic [SEL_BITS-1:0] sel_field,
    output logic [NUM_SEL-1:0]  sel_onehot
);

    // One comparator per select line.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        assign sel_onehot[i] = (sel_field == SEL_BITS'(i));
    end

endmodule

// File: rtl/bridge_front.sv
// System-bus side: accepts address phases, tracks the data phase, loads the
// single holding register and drives hreadyout.
// Assumes: one holding register; writes are posted, reads wait for data.
module bridge_front
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    input  logic              xfer_done,
    output logic              hreadyout,
    output logic              hold_load,
    output logic              hold_valid,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              hold_write,
    output logic [DATA_W-1:0] hold_wdata
);

    logic              accept;
    logic              buffer_free;
    logic              dp_pending;
    logic              dp_write;
    logic              dp_issued;
    logic              rd_done;
    logic [ADDR_W-1:0] dp_addr;

    // Decide whether this cycle starts a transfer.
    assign accept = hsel && hready && ((htrans == HT_NONSEQ) || (htrans == HT_SEQ));

    // The holding register is free if empty or draining in this cycle.
    assign buffer_free = !hold_valid || xfer_done;

    // Move the data-phase transfer into the holding register once it is free.
    assign hold_load = dp_pending && buffer_free && (dp_write || !dp_issued);

    // Ready: no data phase, a posted write taken, or read data now present.
    assign hreadyout = !dp_pending || rd_done || (dp_write && buffer_free);

    // Track the address phase that was taken and its data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_pending <= 1'b0;
            dp_write   <= 1'b0;
            dp_addr    <= '0;
        end else if (accept) begin
            dp_pending <= 1'b1;
            dp_write   <= hwrite;
            dp_addr    <= haddr;
        end else if (hreadyout) begin
            dp_pending <= 1'b0;
        end
    end

    // Note that a read has been handed to the peripheral side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_issued <= 1'b0;
        end else if (hreadyout) begin
            dp_issued <= 1'b0;
        end else if (hold_load) begin
            dp_issued <= 1'b1;
        end
    end

    // Pulse one cycle after a read finishes its enable phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
        end else begin
            rd_done <= xfer_done && !hold_write;
        end
    end

    // Holding register; its contents stay after the transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_addr  <= '0;
            hold_write <= 1'b0;
            hold_wdata <= '0;
        end else if (hold_load) begin
            hold_valid <= 1'b1;
            hold_addr  <= dp_addr;
            hold_write <= dp_write;
            if (dp_write) begin
                hold_wdata <= hwdata;
            end
        end else if (xfer_done) begin
            hold_valid <= 1'b0;
        end
    end

    // A read's enable phase is followed by a ready data phase.
    assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !hold_write) |=> hreadyout);

    // A write waiting behind a busy holding register is not released early.
    assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !xfer_done && dp_pending) |-> !hold_load);

endmodule

// File: rtl/bridge_apb_seq.sv
// Peripheral-side sequencer: idle, setup, enable. Drives the select and enable
// strobes and captures read data at the end of a read's enable phase.
// Assumes: the holding register stays unchanged until the end of the enable phase.
module bridge_apb_seq
    import bridge_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_valid,
    input  logic               hold_load,
    input  logic               hold_write,
    input  logic [NUM_SEL-1:0] sel_onehot,
    input  logic [DATA_W-1:0]  prdata,
    output logic [NUM_SEL-1:0] psel,
    output logic               penable,
    output logic               xfer_done,
    output logic [DATA_W-1:0]  hrdata
);

    apb_phase_e phase_q;
    apb_phase_e phase_d;

    // Next phase: setup runs once, enable chains straight to a new setup.
    always_comb begin
        case (phase_q)
            PH_IDLE:   phase_d = (hold_valid || hold_load) ? PH_SETUP : PH_IDLE;
            PH_SETUP:  phase_d = PH_ENABLE;
            PH_ENABLE: phase_d = hold_load ? PH_SETUP : PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Strobes derived from the phase.
    assign psel      = (phase_q != PH_IDLE) ? sel_onehot : '0;
    assign penable   = (phase_q == PH_ENABLE);
    assign xfer_done = (phase_q == PH_ENABLE);

    // Sample read data at the end of a read's enable phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hrdata <= '0;
        end else if (xfer_done && !hold_write) begin
            hrdata <= prdata;
        end
    end

    // Setup always lasts exactly one cycle.
    assert_setup_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETUP) |=> (phase_q == PH_ENABLE));

endmodule

// File: rtl/sysbus_periph_bridge.sv
// Top level of the bridge: system-bus slave front end, select decoder and
// peripheral-bus sequencer around one holding register.
// Assumes: a single clock for both buses; no error, split or retry responses.
module sysbus_periph_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int SEL_BITS = 2,
    parameter int SEL_LSB  = 12,
    localparam int NUM_SEL = 1 << SEL_BITS
) (
    input  logic               hclk,
    input  logic               hresetn,
    input  logic               hsel,
    input  logic [ADDR_W-1:0]  haddr,
    input  logic [1:0]         htrans,
    input  logic               hwrite,
    input  logic [DATA_W-1:0]  hwdata,
    input  logic               hready,
    output logic               hreadyout,
    output logic [DATA_W-1:0]  hrdata,
    output logic [ADDR_W-1:0]  paddr,
    output logic               pwrite,
    output logic [DATA_W-1:0]  pwdata,
    output logic [NUM_SEL-1:0] psel,
    output logic               penable,
    input  logic [DATA_W-1:0]  prdata
);

    logic               hold_load;
    logic               hold_valid;
    logic [ADDR_W-1:0]  hold_addr;
    logic               hold_write;
    logic [DATA_W-1:0]  hold_wdata;
    logic               xfer_done;
    logic [NUM_SEL-1:0] sel_onehot;

    bridge_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_front (
        .clk        (hclk),
        .rst_n      (hresetn),
        .hsel       (hsel),
        .haddr      (haddr),
        .htrans     (htrans),
        .hwrite     (hwrite),
        .hwdata     (hwdata),
        .hready     (hready),
        .xfer_done  (xfer_done),
        .hreadyout  (hreadyout),
        .hold_load  (hold_load),
        .hold_valid (hold_valid),
        .hold_addr  (hold_addr),
        .hold_write (hold_write),
        .hold_wdata (hold_wdata)
    );

    bridge_sel_decode #(.SEL_BITS(SEL_BITS)) i_decode (
        .sel_field  (hold_addr[SEL_LSB +: SEL_BITS]),
        .sel_onehot (sel_onehot)
    );

    bridge_apb_seq #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) i_seq (
        .clk        (hclk),
        .rst_n      (hresetn),
        .hold_valid (hold_valid),
        .hold_load  (hold_load),
        .hold_write (hold_write),
        .sel_onehot (sel_onehot),
        .prdata     (prdata),
        .psel       (psel),
        .penable    (penable),
        .xfer_done  (xfer_done),
        .hrdata     (hrdata)
    );

    // The holding register drives the peripheral address, direction and data.
    assign paddr  = hold_addr;
    assign pwrite = hold_write;
    assign pwdata = hold_wdata;

    // Peripheral-side signals do not move from setup into enable.
    assert_apb_stable_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata) && $stable(psel)));

    // Never more than one select.
    assert_one_select_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(psel));

    // Enable only with a select, and only after a setup cycle.
    assert_enable_with_select_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |-> (psel != '0));

    assert_enable_after_setup_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        $rose(penable) |-> $past(psel != '0));

endmodule

// File: tb/test_sysbus_periph_bridge.sv
// Self-checking bench: sweeps every select with writes and reads and scripts the
// busy-buffer cases cycle by cycle. Inputs change and outputs are sampled on the falling edge.
module test_sysbus_periph_bridge;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int SEL_BITS = 2;
    localparam int SEL_LSB = 12;
    localparam int NUM_SEL = 1 << SEL_BITS;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               hsel = 1'b0;
    logic [ADDR_W-1:0]  haddr = '0;
    logic [1:0]         htrans = 2'd0;
    logic               hwrite = 1'b0;
    logic [DATA_W-1:0]  hwdata = '0;
    logic               hready_o;
    logic [DATA_W-1:0]  hrdata;
    logic [ADDR_W-1:0]  paddr;
    logic               pwrite;
    logic [DATA_W-1:0]  pwdata;
    logic [NUM_SEL-1:0] psel;
    logic               penable;
    logic [DATA_W-1:0]  prdata;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  mon_en = 1'b0;

    always #2 clk = ~clk;

    // Peripheral model: read data is a function of the address.
    function automatic logic [DATA_W-1:0] periph_val(input logic [ADDR_W-1:0] a);
        return {a ^ 16'h3C5A, a + 16'h0101};
    endfunction
    assign prdata = periph_val(paddr);

    sysbus_periph_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_BITS(SEL_BITS),
                           .SEL_LSB(SEL_LSB)) i_sysbus_periph_bridge (
        .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hready(hready_o), .hreadyout(hready_o),
        .hrdata(hrdata), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
        .psel(psel), .penable(penable), .prdata(prdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NUM_SEL-1:0] exp_sel(input logic [ADDR_W-1:0] a);
        return NUM_SEL'(1) << a[SEL_LSB +: SEL_BITS];
    endfunction

    // Generic peripheral-bus monitor (R4, R5, R6, R9).
    logic               sv_setup = 1'b0;
    logic [ADDR_W-1:0]  sv_addr;
    logic               sv_wr;
    logic [DATA_W-1:0]  sv_wd;
    logic [NUM_SEL-1:0] sv_sel;
    logic               have_last = 1'b0;
    logic [ADDR_W-1:0]  last_addr;
    logic               last_wr;

    always @(negedge clk) begin
        if (mon_en) begin
            if (psel != '0 && !penable) begin
                chk($onehot(psel), "R6 one select", DATA_W'(psel), DATA_W'(exp_sel(paddr)));
                chk(psel == exp_sel(paddr), "R6 select decode", DATA_W'(psel),
                    DATA_W'(exp_sel(paddr)));
                chk(!sv_setup, "R4 setup lasts one cycle", 32'd1, 32'd0);
                sv_setup = 1'b1;
                sv_addr = paddr; sv_wr = pwrite; sv_wd = pwdata; sv_sel = psel;
            end else if (penable) begin
                chk(sv_setup, "R4 enable follows setup", DATA_W'(sv_setup), 32'd1);
                chk(paddr == sv_addr && pwrite == sv_wr && pwdata == sv_wd && psel == sv_sel,
                    "R5 stable into enable", DATA_W'(paddr), DATA_W'(sv_addr));
                sv_setup = 1'b0;
                have_last = 1'b1; last_addr = paddr; last_wr = pwrite;
            end else begin
                chk(!sv_setup, "R4 setup not followed by enable", 32'd0, 32'd1);
                sv_setup = 1'b0;
                if (have_last) begin
                    chk(paddr == last_addr && pwrite == last_wr, "R9 address held",
                        DATA_W'(paddr), DATA_W'(last_addr));
                end
            end
        end
    end

    // Single posted write from an idle bus; caller sits on a falling edge.
    task automatic wr_single(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; haddr = a; hwdata = ~d;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'd0; hwdata = d; haddr = ~a;
        chk(hready_o, "R3 posted write ready in data phase", DATA_W'(hready_o), 32'd1);
        @(negedge clk);
        chk(psel == exp_sel(a) && !penable, "R3 setup next cycle", DATA_W'(psel),
            DATA_W'(exp_sel(a)));
        chk(paddr == a && pwrite, "R3 write address", DATA_W'(paddr), DATA_W'(a));
        chk(pwdata == d, "R10 data-phase write data", pwdata, d);
        @(negedge clk);
        chk(penable == 1'b1, "R4 enable phase", DATA_W'(penable), 32'd1);
        @(negedge clk);
        chk(psel == '0 && !penable && paddr == a, "R9 idle keeps address", DATA_W'(paddr),
            DATA_W'(a));
    endtask

    // Single read from an idle bus.
    task automatic rd_single(input logic [ADDR_W-1:0] a);
        hsel = 1'b1; htrans = 2'd3; hwrite = 1'b0; haddr = a;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'd0; haddr = ~a;
        chk(!hready_o, "R7 stall in data phase", DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(!hready_o && psel == exp_sel(a) && !pwrite, "R7 stall in setup",
            DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(!hready_o && penable, "R7 stall in enable", DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(hready_o, "R7 ready after enable", DATA_W'(hready_o), 32'd1);
        chk(hrdata == periph_val(a), "R7 read data", hrdata, periph_val(a));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(hready_o && psel == '0 && !penable && hrdata == '0, "R1 reset state",
            DATA_W'(hready_o), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        chk(hready_o && psel == '0, "R1 after reset release", DATA_W'(psel), 32'd0);

        // R2: cycles that must not start anything.
        wr_single(16'h1040, 32'hCAFE0001);
        hsel = 1'b1; htrans = 2'd0; hwrite = 1'b1; haddr = 16'h3008;
        @(negedge clk);
        htrans = 2'd1;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'd2;
        @(negedge clk);
        htrans = 2'd0;
        for (int i = 0; i < 4; i++) begin
            chk(psel == '0 && hready_o && paddr == 16'h1040, "R2 ignored cycles",
                DATA_W'(paddr), 32'h1040);
            @(negedge clk);
        end

        // Sweep every select with several offsets.
        for (int s = 0; s < NUM_SEL; s++) begin
            for (int k = 0; k < 3; k++) begin
                logic [ADDR_W-1:0] a;
                a = ADDR_W'((k << 14) | (s << SEL_LSB) | (k * 12'h2A4 + 12'h018));
                wr_single(a, {a, ~a} ^ DATA_W'(k * 32'h01010101));
                rd_single(a);
            end
        end

        // R8: write then write back to back.
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; haddr = 16'h2100; hwdata = '0;
        @(negedge clk);
        chk(hready_o, "R8 first write posted", DATA_W'(hready_o), 32'd1);
        hwdata = 32'h11112222; haddr = 16'h3200; htrans = 2'd3;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'd0; hwdata = 32'h33334444;
        chk(!hready_o && psel == exp_sel(16'h2100), "R8 second write stalls in setup",
            DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(hready_o && penable && paddr == 16'h2100, "R8 released in enable",
            DATA_W'(hready_o), 32'd1);
        @(negedge clk);
        chk(psel == exp_sel(16'h3200) && !penable && paddr == 16'h3200,
            "R8 enable chains to setup", DATA_W'(paddr), 32'h3200);
        chk(pwdata == 32'h33334444, "R10 second write data", pwdata, 32'h33334444);
        @(negedge clk);
        chk(penable, "R8 second enable", DATA_W'(penable), 32'd1);
        @(negedge clk);
        chk(psel == '0 && paddr == 16'h3200 && pwrite, "R9 held after chain",
            DATA_W'(paddr), 32'h3200);

        // R8: write then read back to back.
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; haddr = 16'h0010;
        @(negedge clk);
        hwdata = 32'h5555AAAA; hwrite = 1'b0; haddr = 16'h1234;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'd0;
        chk(!hready_o, "R8 read waits behind write", DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(!hready_o && penable && paddr == 16'h0010, "R8 read stalls in write enable",
            DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(!hready_o && !penable && paddr == 16'h1234 && !pwrite, "R8 read setup chained",
            DATA_W'(paddr), 32'h1234);
        @(negedge clk);
        chk(!hready_o && penable, "R7 read enable", DATA_W'(hready_o), 32'd0);
        @(negedge clk);
        chk(hready_o && hrdata == periph_val(16'h1234), "R7 chained read data", hrdata,
            periph_val(16'h1234));
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule